// File: doc/BRIEF.md
# Magic-state automaton step engine

This block advances a deterministic automaton used for multi-pattern string matching by one transition for each input byte. It holds the current 16-bit state. For every accepted 8-bit symbol it reads two on-chip structures in the same cycle. The first is a per-symbol table holding the most common next state for that symbol, called the magic state. The second is a compressed hint bitmap. In that bitmap, one set bit means that every transition inside a rectangular block of the full transition matrix lands on the symbol's magic state.

When the hint bit is set, the engine takes the next state straight from the on-chip table in a single cycle. When the bit is clear, the engine cannot tell whether the transition is magic. It then issues one read to the large off-chip transition memory, addressed by symbol and state, and waits for the reply. The input side stalls until that reply arrives. Both on-chip tables are filled through simple write ports. Two free-running counters record how many steps were served on-chip and how many needed an external fetch.

A hint bit covers 2^HINT_M consecutive states by 2^HINT_N consecutive symbols. To bound on-chip storage, the bitmap covers only states below 2^COV_W. States above that limit always use the external memory.

Top module: `mstep_engine`

## Requirements
- R1: After reset, cur_state is 0, in_ready is 1, ext_req and step_done are 0, both counters are 0, and every hint bit is 0.
- R2: A symbol accepted (in_valid and in_ready at a rising edge) whose hint bit is 1 makes cur_state equal the magic entry for that symbol at that same edge. step_done and step_hit are 1 for the following cycle, and no external request is made.
- R3: A symbol accepted whose hint bit is 0 raises ext_req for exactly one cycle, starting at the acceptance edge. ext_addr carries the symbol in bits [23:16] and the pre-step state in bits [15:0].
- R4: From the acceptance of a fetching symbol until the response is taken, in_ready is 0, so at most one fetch is outstanding.
- R5: In the cycle after ext_req, or any later cycle while waiting, ext_rvalid loads ext_rdata into cur_state at that edge. step_done is then 1 and step_hit 0 for one cycle, and in_ready returns to 1.
- R6: The hint bit used has bitmap address {symbol >> HINT_N, state[COV_W-1:HINT_M]}. Any state of 2^COV_W (1024) or above always fetches externally, whatever the bitmap holds.
- R7: ext_rvalid arriving while no fetch is outstanding has no effect: cur_state is unchanged and no step_done follows.
- R8: hit_count rises by 1 for every on-chip step, and fetch_count by 1 for every external request.
- R9: A write with mw_en stores mw_state as the magic entry of mw_sym. A write with hw_en stores hw_bit at bitmap address hw_addr, where the row (symbol) is in the upper bits and the state block in the low COV_W-HINT_M bits. Either write takes effect for steps accepted after its edge.
- R10: While in_valid is 0 and no fetch is outstanding, cur_state holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input symbol valid |
| in_sym | input | 8 | Input symbol |
| in_ready | output | 1 | Engine can accept a symbol |
| cur_state | output | 16 | Current automaton state |
| step_done | output | 1 | One-cycle pulse: a transition completed |
| step_hit | output | 1 | Last transition was served on-chip |
| mw_en | input | 1 | Magic table write enable |
| mw_sym | input | 8 | Magic table write symbol |
| mw_state | input | 16 | Magic table write value |
| hw_en | input | 1 | Hint bitmap write enable |
| hw_addr | input | 14 | Hint bitmap bit address {row, state block} |
| hw_bit | input | 1 | Hint bit value written |
| ext_req | output | 1 | External transition read request (one cycle) |
| ext_addr | output | 24 | External read address {symbol, state} |
| ext_rvalid | input | 1 | External read data valid |
| ext_rdata | input | 16 | External read data (next state) |
| hit_count | output | 32 | Count of on-chip transitions |
| fetch_count | output | 32 | Count of external requests |

## Verification
An on-chip step updates cur_state at the acceptance edge, so the bench compares it, together with step_done and step_hit, at the falling edge that follows. A fetching step first shows ext_req and ext_addr at that same falling edge. The memory model then answers one to seven cycles later. The new state and a clear step_hit are due one cycle after the response edge. A scoreboard queue holds the expected state and hit flag of each step, and a monitor compares them only at falling edges where step_done is 1. Any step_done with an empty queue counts as a failure.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2
   } mstep_phase_e;
endpackage

// File: rtl/mstep_magic_tab.sv
module mstep_magic_tab #(
   parameter int SYM_W = 8,
   parameter int ST_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] rd_sym,
   output logic [ST_W-1:0]  rd_state,
   input  logic             wr_en,
   input  logic [SYM_W-1:0] wr_sym,
   input  logic [ST_W-1:0]  wr_state
);
   localparam int ENTRIES = 2 ** SYM_W;

   logic [ST_W-1:0] tab_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
      end else if (wr_en) begin
         tab_q[wr_sym] <= wr_state;
      end
   end

   assign rd_state = tab_q[rd_sym];
endmodule

// File: rtl/mstep_hint_map.sv
module mstep_hint_map #(
   parameter int SYM_W  = 8,
   parameter int ST_W   = 16,
   parameter int HINT_M = 4,
   parameter int HINT_N = 0,
   parameter int COV_W  = 10,
   localparam int ROW_W = SYM_W - HINT_N,
   localparam int COL_W = COV_W - HINT_M,
   localparam int HA_W  = ROW_W + COL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] rd_sym,
   input  logic [ST_W-1:0]  rd_state,
   output logic             hint_hit,
   input  logic             wr_en,
   input  logic [HA_W-1:0]  wr_addr,
   input  logic             wr_bit
);
   localparam int ROWS = 2 ** ROW_W;
   localparam int COLS = 2 ** COL_W;

   logic [COLS-1:0]  map_q [ROWS];
   logic [ROW_W-1:0] rd_row;
   logic [COL_W-1:0] rd_col;
   logic [ROW_W-1:0] wr_row;
   logic [COL_W-1:0] wr_col;
   logic             in_cover;

   assign rd_row = rd_sym[SYM_W-1:HINT_N];
   assign rd_col = rd_state[COV_W-1:HINT_M];
   assign wr_row = wr_addr[HA_W-1:COL_W];
   assign wr_col = wr_addr[COL_W-1:0];

   generate
      if (COV_W == ST_W) begin : g_full_cover
         assign in_cover = 1'b1;
      end else begin : g_part_cover
         assign in_cover = (rd_state[ST_W-1:COV_W] == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ROWS; i++) map_q[i] <= '0;
      end else if (wr_en) begin
         map_q[wr_row][wr_col] <= wr_bit;
      end
   end

   assign hint_hit = in_cover && map_q[rd_row][rd_col];
endmodule

// File: rtl/mstep_ctrl.sv
module mstep_ctrl
   import mstep_pkg::*;
#(
   parameter int SYM_W = 8,
   parameter int ST_W  = 16,
   parameter int CNT_W = 32,
   localparam int XA_W = SYM_W + ST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SYM_W-1:0] in_sym,
   output logic             in_ready,
   input  logic             hint_hit,
   input  logic [ST_W-1:0]  magic_next,
   output logic [ST_W-1:0]  cur_state,
   output logic             step_done,
   output logic             step_hit,
   output logic             ext_req,
   output logic [XA_W-1:0]  ext_addr,
   input  logic             ext_rvalid,
   input  logic [ST_W-1:0]  ext_rdata,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] fetch_count
);
   mstep_phase_e phase_q;

   assign in_ready = (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         cur_state   <= '0;
         step_done   <= 1'b0;
         step_hit    <= 1'b0;
         ext_req     <= 1'b0;
         ext_addr    <= '0;
         hit_count   <= '0;
         fetch_count <= '0;
      end else begin
         step_done <= 1'b0;
         ext_req   <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (in_valid) begin
                  if (hint_hit) begin
                     cur_state <= magic_next;
                     step_done <= 1'b1;
                     step_hit  <= 1'b1;
                     hit_count <= hit_count + CNT_W'(1);
                  end else begin
                     ext_req     <= 1'b1;
                     ext_addr    <= {in_sym, cur_state};
                     fetch_count <= fetch_count + CNT_W'(1);
                     phase_q     <= PH_REQ;
                  end
               end
            end
            PH_REQ: begin
               phase_q <= PH_WAIT;
            end
            PH_WAIT: begin
               if (ext_rvalid) begin
                  cur_state <= ext_rdata;
                  step_done <= 1'b1;
                  step_hit  <= 1'b0;
                  phase_q   <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mstep_engine.sv
module mstep_engine #(
   parameter int SYM_W  = 8,
   parameter int ST_W   = 16,
   parameter int HINT_M = 4,
   parameter int HINT_N = 0,
   parameter int COV_W  = 10,
   parameter int CNT_W  = 32,
   localparam int HA_W  = (SYM_W - HINT_N) + (COV_W - HINT_M),
   localparam int XA_W  = SYM_W + ST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SYM_W-1:0] in_sym,
   output logic             in_ready,
   output logic [ST_W-1:0]  cur_state,
   output logic             step_done,
   output logic             step_hit,
   input  logic             mw_en,
   input  logic [SYM_W-1:0] mw_sym,
   input  logic [ST_W-1:0]  mw_state,
   input  logic             hw_en,
   input  logic [HA_W-1:0]  hw_addr,
   input  logic             hw_bit,
   output logic             ext_req,
   output logic [XA_W-1:0]  ext_addr,
   input  logic             ext_rvalid,
   input  logic [ST_W-1:0]  ext_rdata,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] fetch_count
);
   generate
      if (HINT_N >= SYM_W) begin : g_bad_n
         $error("HINT_N must be below SYM_W");
      end
      if (HINT_M >= COV_W) begin : g_bad_m
         $error("HINT_M must be below COV_W");
      end
      if (COV_W > ST_W) begin : g_bad_cov
         $error("COV_W must not exceed ST_W");
      end
   endgenerate

   logic            hint_hit;
   logic [ST_W-1:0] magic_next;

   mstep_magic_tab #(.SYM_W(SYM_W), .ST_W(ST_W)) u_magic (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_sym   (in_sym),
      .rd_state (magic_next),
      .wr_en    (mw_en),
      .wr_sym   (mw_sym),
      .wr_state (mw_state)
   );

   mstep_hint_map #(
      .SYM_W(SYM_W), .ST_W(ST_W), .HINT_M(HINT_M), .HINT_N(HINT_N), .COV_W(COV_W)
   ) u_hint (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_sym   (in_sym),
      .rd_state (cur_state),
      .hint_hit (hint_hit),
      .wr_en    (hw_en),
      .wr_addr  (hw_addr),
      .wr_bit   (hw_bit)
   );

   mstep_ctrl #(.SYM_W(SYM_W), .ST_W(ST_W), .CNT_W(CNT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sym      (in_sym),
      .in_ready    (in_ready),
      .hint_hit    (hint_hit),
      .magic_next  (magic_next),
      .cur_state   (cur_state),
      .step_done   (step_done),
      .step_hit    (step_hit),
      .ext_req     (ext_req),
      .ext_addr    (ext_addr),
      .ext_rvalid  (ext_rvalid),
      .ext_rdata   (ext_rdata),
      .hit_count   (hit_count),
      .fetch_count (fetch_count)
   );
endmodule

// File: rtl/mstep_engine_chk.sv
module mstep_engine_chk #(
   parameter int ST_W  = 16,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             hint_hit,
   input logic             step_done,
   input logic             step_hit,
   input logic [ST_W-1:0]  cur_state,
   input logic             ext_req,
   input logic             ext_rvalid,
   input logic [ST_W-1:0]  ext_rdata,
   input logic [CNT_W-1:0] hit_count,
   input logic [CNT_W-1:0] fetch_count
);
   // R2
   hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && hint_hit) |=> (step_done && step_hit && !ext_req));

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |=> !ext_req);

   // R4
   req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> !in_ready);

   // R4
   miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !hint_hit) |=> (ext_req && !in_ready));

   // R5
   resp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !ext_req && ext_rvalid) |=>
         (step_done && !step_hit && in_ready && cur_state == $past(ext_rdata)));

   // R7
   stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid && ext_rvalid) |=> !step_done);

   // R8
   fetch_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> (fetch_count == $past(fetch_count) + CNT_W'(1)));

   // R8
   hit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && hint_hit) |=> (hit_count == $past(hit_count) + CNT_W'(1)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> $stable(cur_state));
endmodule

bind mstep_engine mstep_engine_chk #(.ST_W(ST_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .hint_hit    (hint_hit),
   .step_done   (step_done),
   .step_hit    (step_hit),
   .cur_state   (cur_state),
   .ext_req     (ext_req),
   .ext_rvalid  (ext_rvalid),
   .ext_rdata   (ext_rdata),
   .hit_count   (hit_count),
   .fetch_count (fetch_count)
);

// File: tb/mstep_engine_tb.sv
module mstep_engine_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_sym = '0;
   logic        in_ready;
   logic [15:0] cur_state;
   logic        step_done, step_hit;
   logic        mw_en = 1'b0;
   logic [7:0]  mw_sym = '0;
   logic [15:0] mw_state = '0;
   logic        hw_en = 1'b0;
   logic [13:0] hw_addr = '0;
   logic        hw_bit = 1'b0;
   logic        ext_req;
   logic [23:0] ext_addr;
   logic        ext_rvalid;
   logic [15:0] ext_rdata;
   logic [31:0] hit_count, fetch_count;

   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        stray_v = 1'b0;
   assign ext_rvalid = mem_rvalid | stray_v;
   assign ext_rdata  = stray_v ? 16'h1234 : mem_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   mstep_engine u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
      .in_ready(in_ready), .cur_state(cur_state), .step_done(step_done),
      .step_hit(step_hit), .mw_en(mw_en), .mw_sym(mw_sym), .mw_state(mw_state),
      .hw_en(hw_en), .hw_addr(hw_addr), .hw_bit(hw_bit), .ext_req(ext_req),
      .ext_addr(ext_addr), .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata),
      .hit_count(hit_count), .fetch_count(fetch_count)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [15:0] magic_ref [256];
   logic        hint_ref  [256][64];
   logic [15:0] exp_state = '0;
   logic [23:0] exp_addr = '0;
   int          n_hit = 0;
   int          n_fetch = 0;
   int          fetch_idx = 0;

   typedef struct packed { logic [15:0] nxt; logic hit; } exp_t;
   exp_t exp_q [$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference full transition table of the bench automaton
   function automatic logic [15:0] ref_a(input logic [7:0] s, input logic [15:0] st);
      if (s == 8'h7F) return 16'd0;
      if (s < 8'h30) return 16'(st * 3 + 16'(s));
      if (s >= 8'h31 && s <= 8'h35 && st < 16'd64) return magic_ref[s];
      return (st ^ {s, s}) + 16'd1;
   endfunction

   task automatic put_magic(input logic [7:0] s, input logic [15:0] v);
      mw_en = 1'b1; mw_sym = s; mw_state = v;
      magic_ref[s] = v;
      @(negedge clk);
      mw_en = 1'b0;
   endtask

   task automatic put_hint(input logic [7:0] s, input logic [5:0] blk, input logic b);
      hw_en = 1'b1; hw_addr = {s, blk}; hw_bit = b;
      hint_ref[s][blk] = b;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   // Driver: pushes expected result, presents one symbol, waits for the monitor
   task automatic step(input logic [7:0] s);
      exp_t e;
      while (!in_ready) @(negedge clk);
      e.hit = (exp_state < 16'd1024) && hint_ref[s][exp_state[9:4]];
      e.nxt = e.hit ? magic_ref[s] : ref_a(s, exp_state);
      exp_addr = {s, exp_state};
      exp_q.push_back(e);
      in_valid = 1'b1; in_sym = s;
      @(negedge clk);
      in_valid = 1'b0;
      if (e.hit) n_hit++; else n_fetch++;
      exp_state = e.nxt;
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   // Monitor: compares each completed transition with the queue head
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && step_done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected step_done", 32'(cur_state), 32'hFFFF_FFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(cur_state == e.nxt, e.hit ? "R2 on-chip next state" : "R5 fetched next state",
                   32'(cur_state), 32'(e.nxt));
               chk(step_hit == e.hit, "R6 hint decision (step_hit)", 32'(step_hit), 32'(e.hit));
            end
         end
      end
   end

   // External memory model with varying latency
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ext_req) begin
            int lat;
            chk(ext_addr == exp_addr, "R3 ext_addr", 32'(ext_addr), 32'(exp_addr));
            chk(in_ready == 1'b0, "R4 in_ready low during fetch", 32'(in_ready), 0);
            lat = 1 + (fetch_idx % 4) * 2;
            fetch_idx++;
            for (int i = 0; i < lat; i++) begin
               @(negedge clk);
               if (i == 0) chk(ext_req == 1'b0, "R3 ext_req single cycle", 32'(ext_req), 0);
               if (i > 0) chk(in_ready == 1'b0, "R4 in_ready held low", 32'(in_ready), 0);
            end
            mem_rvalid = 1'b1;
            mem_rdata  = ref_a(ext_addr[23:16], ext_addr[15:0]);
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         magic_ref[i] = '0;
         for (int j = 0; j < 64; j++) hint_ref[i][j] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cur_state == 16'd0, "R1 cur_state", 32'(cur_state), 0);
      chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
      chk(ext_req == 1'b0, "R1 ext_req", 32'(ext_req), 0);
      chk(step_done == 1'b0, "R1 step_done", 32'(step_done), 0);
      chk(hit_count == 0 && fetch_count == 0, "R1 counters", hit_count + fetch_count, 0);

      // R9: magic entries loaded, hints still all zero -> fetch
      put_magic(8'h31, 16'd178);
      put_magic(8'h32, 16'd671);
      put_magic(8'h33, 16'd2718);
      put_magic(8'h34, 16'd2732);
      put_magic(8'h35, 16'd4600);
      step(8'h23);                 // 0 -> 35, fetched
      put_hint(8'h34, 6'd2, 1'b1); // states 32..47 with 0x34
      put_hint(8'h32, 6'd0, 1'b1); // states 0..15 with 0x32
      put_hint(8'h32, 6'd42, 1'b1);// aliases state 2732 outside cover
      put_hint(8'h35, 6'd0, 1'b1);

      step(8'h34);                 // R2: 35 -> 2732 on-chip
      step(8'h32);                 // R6: 2732 beyond cover -> fetch
      step(8'h7F);
      step(8'h32);                 // R2: 0 -> 671 on-chip
      step(8'h7F);
      step(8'h2A);                 // 0 -> 42
      step(8'h31);                 // R5: 42 fetches 178
      step(8'h7F);
      step(8'h28);                 // 40
      step(8'h34);                 // R6: same block as 35, on-chip
      step(8'h7F);
      step(8'h2F);                 // 47
      step(8'h34);                 // R6: block edge, on-chip
      step(8'h7F);
      step(8'h01);
      step(8'h2D);                 // 48
      step(8'h34);                 // R6: next block, fetch

      // R7: stray response while idle
      begin
         logic [15:0] hold;
         hold = cur_state;
         stray_v = 1'b1;
         @(negedge clk);
         stray_v = 1'b0;
         repeat (2) @(negedge clk);
         chk(cur_state == hold, "R7 stray response ignored", 32'(cur_state), 32'(hold));
      end

      // R10: idle hold
      begin
         logic [15:0] hold;
         hold = cur_state;
         in_sym = 8'h34;
         repeat (5) @(negedge clk);
         chk(cur_state == hold, "R10 idle hold", 32'(cur_state), 32'(hold));
      end

      // R9: table rewrites take effect
      step(8'h7F);
      step(8'h35);                 // 4600 on-chip
      put_magic(8'h35, 16'd999);
      step(8'h7F);
      step(8'h35);                 // 999 on-chip
      put_hint(8'h35, 6'd0, 1'b0);
      step(8'h7F);
      step(8'h35);                 // cleared hint: fetch
      chk(step_hit == 1'b0, "R9 cleared hint fetches", 32'(step_hit), 0);

      // R8 counters
      chk(hit_count == 32'(n_hit), "R8 hit_count", hit_count, 32'(n_hit));
      chk(fetch_count == 32'(n_fetch), "R8 fetch_count", fetch_count, 32'(n_fetch));
      chk(cur_state == exp_state, "R5 final state", 32'(cur_state), 32'(exp_state));

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule